// File: doc/BRIEF.md
# Run-Length Compressed Table Lookup

This block turns a query index into a 16-bit value held in compressed form in an external synchronous ROM. The index arrives as two bytes on a byte strobe. The first byte is the high half and the second is the low half. Once it has both bytes, the block walks the ROM from address zero. It decodes each 10-bit entry as either a run of identical values or a single literal. It keeps a running count of the logical positions covered so far. When the requested position falls inside an entry, it rebuilds the value and raises a one-cycle valid strobe.

Literals come in two alignments. A small literal lands in the low byte of the result. A large literal has result bit 14 set and fills bits 13:6. The low six bits of a large value are taken from a free-running counter at the moment the result is shown. This gives those bits a noise-like spread.

The state machine has five states:
- `S_IDLE`: waits for the first byte.
- `S_HALF`: holds the high byte and waits for the second.
- `S_ISSUE`: the ROM address is presented.
- `S_DECODE`: the ROM data is valid and is judged.
- `S_DONE`: the result is shown.

Its transitions are:
- first-byte (`S_IDLE`→`S_HALF`)
- second-byte-in-range (`S_HALF`→`S_ISSUE`)
- second-byte-out-of-range (`S_HALF`→`S_DONE`)
- read-wait (`S_ISSUE`→`S_DECODE`)
- miss-advance (`S_DECODE`→`S_ISSUE`)
- hit (`S_DECODE`→`S_DONE`)
- retire (`S_DONE`→`S_IDLE`)

Top module: `rle_table_lookup`

## Requirements
- R1: The query index equals the first accepted byte times 256 plus the second accepted byte. A byte is accepted on a clock edge where `byte_valid` is high while the block is waiting for a byte. The two bytes need not be on consecutive cycles.
- R2: A ROM entry with bit 9 = 1 is a run. Bit 8 is the repeated value (result 16'h0001 or 16'h0000), and bits 7:0 are its length N. The entry covers the next N logical positions, and an entry with N = 0 covers none.
- R3: A ROM entry with bit 9 = 0 and bit 8 = 0 is a small literal. It covers one position, and its result is bits 7:0 zero-extended to 16 bits.
- R4: A ROM entry with bit 9 = 0 and bit 8 = 1 is a large literal. It covers one position. Its result has bit 15 = 0 and bit 14 = 1, bits 13:6 equal entry bits 7:0, and bits 5:0 equal the number of clock edges since reset release modulo 64, counted in the cycle `result_valid` is high.
- R5: An index of 15360 or more gives `result` = 0 with `result_err` = 1. In that case `result_valid` comes one cycle after the second byte is accepted, and no ROM scan takes place. `result_err` is 0 for every in-range index.
- R6: `busy` is high from the edge that accepts the second byte of an in-range query until the result is valid. It is low in the valid cycle and in idle. Bytes strobed while `busy` is high, or in the valid cycle, are ignored.
- R7: If the requested position lies in ROM entry k (counting from 0, zero-length runs included), `result_valid` rises exactly 2(k+1) edges after the edge that accepted the second byte.
- R8: `result_valid` is a single-cycle pulse per query, and the block accepts a new first byte on the next edge.
- R9: After reset, `busy`, `result_valid` and `result_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | Strobe qualifying `byte_in` |
| byte_in | input | 8 | Query byte, high half first |
| rom_addr | output | ADDR_W | ROM read address |
| rom_data | input | 10 | ROM read data, one cycle after the address |
| busy | output | 1 | Scan in progress |
| result_valid | output | 1 | One-cycle strobe, result present |
| result | output | 16 | Rebuilt table value |
| result_err | output | 1 | Index out of range, qualified by `result_valid` |

## Verification
The ROM holds the following, in order:
- a small literal and a large literal,
- a zero-length run,
- a short run and a small literal of value zero,
- another large literal,
- sixty full-length runs of alternating values,
- a partial run,
- two literals at the very last positions.

Queries at the first and last position of neighbouring runs show whether the position count is off by one. The query on the zero-length run shows whether empty entries are counted as covering a position. The end-of-table and just-out-of-range indices, 15359 and 15360, separate the last valid lookup from the error path. Queries with gaps between the two bytes, and queries with junk bytes strobed during the scan, separate correct byte acceptance from bytes that leak into the index. The model compares the cycle of every valid pulse, which exposes a wrong ROM-latency wait. Large-literal results are compared against the bench's own edge count, which exposes a counter sampled in the wrong cycle.

// File: rtl/rle_lookup_pkg.sv
package rle_lookup_pkg;

    localparam int ENTRY_W  = 10;
    localparam int RUN_FLAG = 9;
    localparam int SEL_BIT  = 8;
    localparam int FIELD_W  = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HALF,
        S_ISSUE,
        S_DECODE,
        S_DONE
    } scan_state_t;

    typedef enum logic [1:0] {
        K_ZERO,
        K_ONE,
        K_SMALL,
        K_LARGE
    } res_kind_t;

endpackage

// File: rtl/rle_entry_decode.sv
module rle_entry_decode
    import rle_lookup_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    output logic               is_run,
    output logic               sel,
    output logic [FIELD_W-1:0] field
);

    always_comb begin
        is_run = entry[RUN_FLAG];
        sel    = entry[SEL_BIT];
        field  = entry[FIELD_W-1:0];
    end

endmodule

// File: rtl/rle_free_counter.sv
module rle_free_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end

endmodule

// File: rtl/rle_scan_fsm.sv
module rle_scan_fsm
    import rle_lookup_pkg::*;
#(
    parameter int DEPTH  = 15360,
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_valid,
    input  logic [7:0]         byte_in,
    input  logic               ent_run,
    input  logic               ent_sel,
    input  logic [FIELD_W-1:0] ent_field,
    output logic [ADDR_W-1:0]  ptr,
    output logic               busy,
    output logic               done,
    output logic               err,
    output res_kind_t          kind,
    output logic [FIELD_W-1:0] lit_byte
);

    localparam int POS_W = IDX_W + 1;

    scan_state_t        state_q, state_d;
    logic [7:0]         hi_q;
    logic [IDX_W-1:0]   idx_q;
    logic [POS_W-1:0]   pos_q;
    logic [ADDR_W-1:0]  ptr_q;
    logic               err_q;
    res_kind_t          kind_q;
    logic [FIELD_W-1:0] byte_q;
    logic [IDX_W-1:0]   new_idx;
    logic               out_range;
    logic [POS_W-1:0]   run_end;
    logic               hit;

    always_comb begin
        new_idx   = {hi_q, byte_in};
        out_range = ({1'b0, new_idx} >= POS_W'(DEPTH));
        run_end   = pos_q + POS_W'(ent_field);
        if (ent_run) hit = ({1'b0, idx_q} < run_end);
        else         hit = ({1'b0, idx_q} == pos_q);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (byte_valid) state_d = S_HALF;
            S_HALF:   if (byte_valid) state_d = out_range ? S_DONE : S_ISSUE;
            S_ISSUE:  state_d = S_DECODE;
            S_DECODE: state_d = hit ? S_DONE : S_ISSUE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            idx_q  <= '0;
            pos_q  <= '0;
            ptr_q  <= '0;
            err_q  <= 1'b0;
            kind_q <= K_ZERO;
            byte_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (byte_valid) hi_q <= byte_in;
                S_HALF: if (byte_valid) begin
                    idx_q  <= new_idx;
                    pos_q  <= '0;
                    ptr_q  <= '0;
                    err_q  <= out_range;
                    kind_q <= K_ZERO;
                    byte_q <= '0;
                end
                S_DECODE: begin
                    if (hit) begin
                        if (ent_run) begin
                            kind_q <= ent_sel ? K_ONE : K_ZERO;
                        end else begin
                            kind_q <= ent_sel ? K_LARGE : K_SMALL;
                            byte_q <= ent_field;
                        end
                    end else begin
                        pos_q <= ent_run ? run_end : pos_q + 1'b1;
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        ptr      = ptr_q;
        busy     = (state_q == S_ISSUE) || (state_q == S_DECODE);
        done     = (state_q == S_DONE);
        err      = (state_q == S_DONE) && err_q;
        kind     = kind_q;
        lit_byte = byte_q;
    end

    // R7: the address must not move while its read data is being judged
    p_decode_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DECODE) |-> $stable(ptr_q));

    // R6: once busy, the block stays busy until a result appears
    p_busy_until_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R8: valid is a one-cycle pulse followed by a non-busy cycle
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

// File: rtl/rle_table_lookup.sv
module rle_table_lookup
    import rle_lookup_pkg::*;
#(
    parameter int DEPTH  = 15360,
    parameter int ADDR_W = 10,
    parameter int LOW_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_valid,
    input  logic [7:0]         byte_in,
    output logic [ADDR_W-1:0]  rom_addr,
    input  logic [ENTRY_W-1:0] rom_data,
    output logic               busy,
    output logic               result_valid,
    output logic [15:0]        result,
    output logic               result_err
);

    localparam int RES_W = 2 + FIELD_W + LOW_W;

    logic               ent_run;
    logic               ent_sel;
    logic [FIELD_W-1:0] ent_field;
    logic [LOW_W-1:0]   noise;
    res_kind_t          kind;
    logic [FIELD_W-1:0] lit_byte;
    logic               done;
    logic               err;

    rle_entry_decode u_dec (
        .entry  (rom_data),
        .is_run (ent_run),
        .sel    (ent_sel),
        .field  (ent_field)
    );

    rle_free_counter #(.W(LOW_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .count (noise)
    );

    rle_scan_fsm #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(16)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .ent_run    (ent_run),
        .ent_sel    (ent_sel),
        .ent_field  (ent_field),
        .ptr        (rom_addr),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .kind       (kind),
        .lit_byte   (lit_byte)
    );

    always_comb begin
        result_valid = done;
        result_err   = err;
        unique case (kind)
            K_ZERO:  result = '0;
            K_ONE:   result = 16'd1;
            K_SMALL: result = {{(16-FIELD_W){1'b0}}, lit_byte};
            K_LARGE: result = 16'({2'b01, lit_byte, noise});
            default: result = '0;
        endcase
    end

    // R5: an out-of-range query reports a zero value
    p_err_result_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        result_err |-> (result_valid && result == 16'd0));

    // R4: the top result bit never appears on a valid result
    p_msb_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> !result[15]);

    initial begin
        assert (RES_W == 16) else $error("field widths must add to 16");
    end

endmodule

// File: tb/rle_table_lookup_tb.sv
module rle_table_lookup_tb;

    localparam int DEPTH  = 15360;
    localparam int ADDR_W = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = '0;
    logic [ADDR_W-1:0] rom_addr;
    logic [9:0]  rom_data;
    logic        busy, result_valid, result_err;
    logic [15:0] result;

    logic [9:0]  rom_mem [0:(1<<ADDR_W)-1];
    int          n_entries = 0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rle_table_lookup #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LOW_W(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
        .rom_addr(rom_addr), .rom_data(rom_data), .busy(busy),
        .result_valid(result_valid), .result(result), .result_err(result_err)
    );

    always @(posedge clk) rom_data <= rom_mem[rom_addr];

    // reference model state
    typedef enum int {M_IDLE, M_HALF, M_RUN, M_DONE} mstate_t;
    mstate_t     m_state = M_IDLE;
    logic [7:0]  m_hi;
    int          m_rem;
    bit          m_err;
    logic [9:0]  m_entry;
    int unsigned edges = 0;

    task automatic put(input logic [9:0] e);
        rom_mem[n_entries] = e;
        n_entries++;
    endtask

    task automatic find(input int idx, output int k, output logic [9:0] e);
        int pos = 0;
        k = -1;
        e = '0;
        for (int i = 0; i < n_entries; i++) begin
            int span = rom_mem[i][9] ? int'(rom_mem[i][7:0]) : 1;
            if (k < 0 && idx < pos + span) begin
                k = i;
                e = rom_mem[i];
            end
            pos += span;
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (edge %0d)", tag, act, exp, edges);
        end
    endtask

    task automatic tick(input logic bv, input logic [7:0] b);
        int          k;
        logic [9:0]  e;
        logic [15:0] idx;
        logic [15:0] exp_res;
        string       tag;
        byte_valid = bv;
        byte_in    = b;
        case (m_state)
            M_IDLE: if (bv) begin m_hi = b; m_state = M_HALF; end
            M_HALF: if (bv) begin
                idx = {m_hi, b};
                if (int'(idx) >= DEPTH) begin
                    m_err = 1; m_state = M_DONE;
                end else begin
                    find(int'(idx), k, e);
                    m_err = 0; m_entry = e; m_rem = 2 * (k + 1); m_state = M_RUN;
                end
            end
            M_RUN: begin
                m_rem--;
                if (m_rem == 0) m_state = M_DONE;
            end
            M_DONE: m_state = M_IDLE;
            default: m_state = M_IDLE;
        endcase
        @(negedge clk);
        edges++;
        check("R6 busy", {31'd0, busy}, {31'd0, m_state == M_RUN});
        check("R7 valid timing", {31'd0, result_valid}, {31'd0, m_state == M_DONE});
        if (m_state == M_DONE && result_valid) begin
            if (m_err) begin
                exp_res = 16'd0; tag = "R5 out of range";
            end else if (m_entry[9]) begin
                exp_res = m_entry[8] ? 16'd1 : 16'd0; tag = "R2 run";
            end else if (m_entry[8]) begin
                exp_res = {2'b01, m_entry[7:0], edges[5:0]}; tag = "R4 large literal";
            end else begin
                exp_res = {8'd0, m_entry[7:0]}; tag = "R3 small literal";
            end
            check(tag, {16'd0, result}, {16'd0, exp_res});
            check("R5 err flag", {31'd0, result_err}, {31'd0, m_err});
        end
    endtask

    // R1, R8: a query with optional gap between bytes, optional junk while busy
    task automatic query(input int idx, input int gap, input bit junk);
        tick(1'b1, idx[15:8]);
        for (int g = 0; g < gap; g++) tick(1'b0, 8'hEE);
        tick(1'b1, idx[7:0]);
        for (int guard = 0; guard < 400 && m_state != M_IDLE; guard++)
            tick(junk, 8'h5A);
        tick(1'b0, 8'h00);
    endtask

    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++) rom_mem[i] = '0;
        put(10'b00_1010_0101);            // pos 0: small literal A5
        put(10'b01_0011_1100);            // pos 1: large literal 3C
        put(10'b11_0000_0000);            // empty run
        put(10'b11_0000_0011);            // pos 2..4: run of ones
        put(10'b00_0000_0000);            // pos 5: small literal 0
        put(10'b01_1111_1111);            // pos 6: large literal FF
        for (int r = 0; r < 60; r++)      // pos 7..15306
            put({1'b1, r[0], 8'd255});
        put({1'b1, 1'b1, 8'd51});         // pos 15307..15357
        put(10'b00_0111_1110);            // pos 15358: small literal 7E
        put(10'b01_1000_0001);            // pos 15359: large literal 81

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        check("R9 busy", {31'd0, busy}, 32'd0);
        check("R9 valid", {31'd0, result_valid}, 32'd0);
        check("R9 err", {31'd0, result_err}, 32'd0);

        query(0, 0, 0);          // R3
        query(1, 0, 0);          // R4
        query(2, 0, 0);          // R2 first run position after empty run
        query(4, 3, 0);          // R2 last of short run, R1 gap
        query(5, 0, 0);          // R3 zero value
        query(6, 0, 1);          // R4, R6 junk while busy
        query(7, 0, 0);          // R2 first long run
        query(261, 0, 0);        // R2 last of first long run
        query(262, 2, 0);        // R2 first of second long run
        query(256, 0, 0);        // R1 high byte weight
        query(15306, 0, 1);      // R2 end of last full run
        query(15357, 0, 0);      // R2 partial run end
        query(15358, 0, 0);      // R3 end of table
        query(15359, 0, 1);      // R4 last position
        query(15360, 0, 0);      // R5 first out of range
        query(65535, 1, 0);      // R5
        query(4, 0, 0);          // R8 block still answers after error
        for (int i = 0; i < 5; i++) tick(1'b0, 8'h00);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule